// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines (32 by default) and presents a single interrupt signal to the processor. Each line has a mask bit, where a one means the line is masked. Software never writes the mask word directly. One register offset sets mask bits, another clears them, and in each case a zero in the written word leaves that line alone. Two or more software agents can therefore change their own lines without a read-modify-write race.

Among the lines that are both high and unmasked, the lowest-numbered one wins. Software can read the winner as a one-hot word or as a binary line number. The number reads as all ones when no unmasked line is active. By system convention line 0 carries the timer, line 1 the keyboard and line 2 the network interface. The block itself treats all lines alike.

Register reads are combinational from the address. A write takes effect at the rising clock edge on which `reg_wr` is high.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every line is masked. Offset 0 reads 0xFFFFFFFF, `irq_out` is low for any line levels, and offset 20 reads 0xFFFFFFFF.
- R2: Offset 0 reads the mask word, with bit n = 1 meaning line n is masked. A write to offset 0 leaves the mask unchanged.
- R3: A write to offset 4 sets every mask bit whose written bit is 1. Mask bits under written zeros keep their value.
- R4: A write to offset 8 clears every mask bit whose written bit is 1. Mask bits under written zeros keep their value.
- R5: Offset 12 reads the live level of every request line, whether or not the line is masked.
- R6: Offset 16 reads a word with at most one bit set. That bit marks the winning line, and the word is zero when no unmasked line is high.
- R7: Offset 20 reads the winning line number as an unsigned integer. It reads 0xFFFFFFFF when no unmasked line is high.
- R8: `irq_out` is high in the same cycle that any line is both high and unmasked, and low otherwise.
- R9: When several unmasked lines are high, the lowest-numbered one wins. A masked line never wins.
- R10: Offsets 4 and 8 read as zero. Every other offset reads as zero, and writes to those other offsets do not change the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive request lines, bit n is line n |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request to the processor |

## Verification
The priority encoder is driven with three kinds of request pattern:
- Several unmasked lines high together, which shows that the lowest number wins.
- A masked low line beside an unmasked higher one, which shows that the mask is applied before the priority decision.
- Only the extreme lines (0 and 31) high, which exposes off-by-one errors in the index encoding.

Mask writes use sparse patterns whose written zeros fall on bits that are currently set and on bits that are currently clear. This separates a true bit-wise set or clear from a plain overwrite of the mask. Writes to offset 0 and to unmapped offsets are each followed by a mask read, which proves they had no effect.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // register byte offsets
   localparam int unsigned OFS_MASK    = 0;
   localparam int unsigned OFS_SET     = 4;
   localparam int unsigned OFS_CLR     = 8;
   localparam int unsigned OFS_LEVEL   = 12;
   localparam int unsigned OFS_WIN_BIT = 16;
   localparam int unsigned OFS_WIN_NUM = 20;

   // system line assignment
   localparam int unsigned LINE_TIMER = 0;
   localparam int unsigned LINE_KEYS  = 1;
   localparam int unsigned LINE_NET   = 2;

   typedef enum logic [2:0] {
      SEL_MASK, SEL_SET, SEL_CLR, SEL_LEVEL, SEL_WBIT, SEL_WNUM, SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input int unsigned ofs);
      case (ofs)
         OFS_MASK:    return SEL_MASK;
         OFS_SET:     return SEL_SET;
         OFS_CLR:     return SEL_CLR;
         OFS_LEVEL:   return SEL_LEVEL;
         OFS_WIN_BIT: return SEL_WBIT;
         OFS_WIN_NUM: return SEL_WNUM;
         default:     return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [N-1:0] wbits,
   output logic [N-1:0] mask_q
);
   // a one in mask_q masks the line; reset masks everything
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '1;
      else if (set_we)
         mask_q <= mask_q | wbits;
      else if (clr_we)
         mask_q <= mask_q & ~wbits;
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N         = 32,
   parameter int unsigned ENC_STYLE = 0,   // 0: scan loop, 1: two's-complement isolate
   localparam int unsigned IDX_W    = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     win_bit,
   output logic [IDX_W-1:0] win_idx,
   output logic             win_any
);
   if (ENC_STYLE > 1) begin : g_bad_style
      $error("irq_prio_enc: ENC_STYLE must be 0 or 1");
   end

   if (ENC_STYLE == 0) begin : g_scan
      always_comb begin
         win_bit = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) win_bit = N'(1) << i;
         end
      end
   end else begin : g_isolate
      // lowest set bit survives x & -x
      always_comb win_bit = req & (~req + N'(1));
   end

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (win_bit[i]) win_idx = win_idx | IDX_W'(i);
      end
   end

   assign win_any = |req;
endmodule

// File: rtl/irq_reg_rdmux.sv
module irq_reg_rdmux
   import irq_pkg::*;
#(
   parameter int unsigned N      = 32,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  reg_sel_e          sel,
   input  logic [N-1:0]      mask_q,
   input  logic [N-1:0]      lines,
   input  logic [N-1:0]      win_bit,
   input  logic [IDX_W-1:0]  win_idx,
   input  logic              win_any,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      unique case (sel)
         SEL_MASK:  rdata = DATA_W'(mask_q);
         SEL_LEVEL: rdata = DATA_W'(lines);
         SEL_WBIT:  rdata = DATA_W'(win_bit);
         SEL_WNUM:  rdata = win_any ? DATA_W'(win_idx) : '1;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned ENC_STYLE = 0,
   localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);
   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("irq_prio_ctrl: NUM_LINES must be 1..DATA_W");
   end
   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
      $error("irq_prio_ctrl: ADDR_W must be 5..32");
   end

   reg_sel_e             sel;
   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] pending;
   logic [NUM_LINES-1:0] win_bit;
   logic [IDX_W-1:0]     win_idx;
   logic                 win_any;

   assign sel = decode_ofs(32'(reg_addr));

   irq_mask_reg #(.N(NUM_LINES)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (reg_wr && sel == SEL_SET),
      .clr_we (reg_wr && sel == SEL_CLR),
      .wbits  (reg_wdata[NUM_LINES-1:0]),
      .mask_q (mask_q)
   );

   assign pending = irq_lines & ~mask_q;

   irq_prio_enc #(.N(NUM_LINES), .ENC_STYLE(ENC_STYLE)) u_enc (
      .req     (pending),
      .win_bit (win_bit),
      .win_idx (win_idx),
      .win_any (win_any)
   );

   irq_reg_rdmux #(.N(NUM_LINES), .DATA_W(DATA_W)) u_rd (
      .sel     (sel),
      .mask_q  (mask_q),
      .lines   (irq_lines),
      .win_bit (win_bit),
      .win_idx (win_idx),
      .win_any (win_any),
      .rdata   (reg_rdata)
   );

   assign irq_out = win_any;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
   import irq_pkg::*;
#(
   parameter int unsigned N      = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      irq_lines,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq_out,
   input logic [N-1:0]      mask_q,
   input logic [N-1:0]      win_bit
);
   logic wr_set, wr_clr;
   assign wr_set = reg_wr && reg_addr == ADDR_W'(OFS_SET);
   assign wr_clr = reg_wr && reg_addr == ADDR_W'(OFS_CLR);

   assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((mask_q & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0])));

   assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((mask_q & $past(reg_wdata[N-1:0])) == '0));

   assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_set || wr_clr) |=> $stable(mask_q));

   assert_onehot_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_bit));

   assert_win_eligible_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (win_bit & (mask_q | ~irq_lines)) == '0);

   assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (win_bit != '0) |-> (((win_bit - N'(1)) & irq_lines & ~mask_q) == '0));

   assert_irq_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == ((irq_lines & ~mask_q) != '0));

   assert_none_sentinel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_WIN_NUM) && win_bit == '0) |-> (reg_rdata == '1));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .N(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .irq_out(irq_out), .mask_q(mask_q), .win_bit(win_bit)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lines = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_prio_ctrl i_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      irq_lines = '1;
      #1;
      rd(8'd0, v);  chk("R1 mask after reset", v, 32'hFFFF_FFFF);
      chk("R1 irq_out low", {31'd0, irq_out}, 32'd0);
      rd(8'd20, v); chk("R1 number sentinel", v, 32'hFFFF_FFFF);
      rd(8'd16, v); chk("R6 no winner bit", v, 32'd0);
   endtask

   task automatic t_level;
      logic [31:0] v;
      irq_lines = 32'hA5A5_0003;
      rd(8'd12, v); chk("R5 live level", v, 32'hA5A5_0003);
      irq_lines = 32'h0F0F_8000;
      rd(8'd12, v); chk("R5 live level 2", v, 32'h0F0F_8000);
   endtask

   task automatic t_set_clr;
      logic [31:0] v;
      wr(8'd8, 32'h0000_00F0);
      rd(8'd0, v); chk("R4 clear bits", v, 32'hFFFF_FF0F);
      wr(8'd8, 32'h0000_0001);
      rd(8'd0, v); chk("R4 clear keeps others", v, 32'hFFFF_FF0E);
      wr(8'd4, 32'h0000_0010);
      rd(8'd0, v); chk("R3 set keeps others", v, 32'hFFFF_FF1E);
      rd(8'd4, v); chk("R10 set reg reads zero", v, 32'd0);
      rd(8'd8, v); chk("R10 clear reg reads zero", v, 32'd0);
   endtask

   task automatic t_prio;
      logic [31:0] v;
      // unmasked: 0,5,6,7
      irq_lines = 32'h0000_00E0;
      rd(8'd16, v); chk("R9 lowest of 5,6,7 bit", v, 32'h20);
      rd(8'd20, v); chk("R7 lowest of 5,6,7 num", v, 32'd5);
      chk("R8 irq high", {31'd0, irq_out}, 32'd1);
      irq_lines = 32'h0000_0081;
      rd(8'd16, v); chk("R6 line 0 bit", v, 32'h1);
      rd(8'd20, v); chk("R7 line 0 num", v, 32'd0);
      irq_lines = 32'h0000_0090;
      rd(8'd20, v); chk("R9 masked 4 loses to 7", v, 32'd7);
      irq_lines = 32'h0000_0010;
      rd(8'd16, v); chk("R6 masked only bit", v, 32'd0);
      rd(8'd20, v); chk("R7 masked only sentinel", v, 32'hFFFF_FFFF);
      chk("R8 irq low masked", {31'd0, irq_out}, 32'd0);
      wr(8'd8, 32'hFFFF_FFFF);
      irq_lines = 32'h8000_0000;
      rd(8'd16, v); chk("R6 line 31 bit", v, 32'h8000_0000);
      rd(8'd20, v); chk("R7 line 31 num", v, 32'd31);
      irq_lines = '0;
      rd(8'd20, v); chk("R7 idle sentinel", v, 32'hFFFF_FFFF);
      chk("R8 irq low idle", {31'd0, irq_out}, 32'd0);
   endtask

   task automatic t_ignored;
      logic [31:0] v;
      wr(8'd4, 32'h0F0F_0F0F);
      rd(8'd0, v); chk("R3 set from zero", v, 32'h0F0F_0F0F);
      wr(8'd0, 32'hFFFF_FFFF);
      rd(8'd0, v); chk("R2 write to mask ignored", v, 32'h0F0F_0F0F);
      wr(8'd24, 32'hFFFF_FFFF);
      wr(8'd5, 32'hFFFF_FFFF);
      wr(8'd12, 32'h0000_0000);
      rd(8'd0, v); chk("R10 unmapped writes ignored", v, 32'h0F0F_0F0F);
      irq_lines = 32'hFFFF_FFFF;
      rd(8'd24, v); chk("R10 unmapped reads zero", v, 32'd0);
      rd(8'd20, v); chk("R9 first unmasked is 4", v, 32'd4);
      wr(8'd4, 32'hFFFF_FFFF);
      chk("R8 all masked irq low", {31'd0, irq_out}, 32'd0);
      wr(8'd8, 32'h0000_0008);
      chk("R8 unmask 3 irq high", {31'd0, irq_out}, 32'd1);
      rd(8'd20, v); chk("R7 line 3 num", v, 32'd3);
   endtask

   initial begin : watchdog
      #(5 * 100000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_level();
      t_set_clr();
      t_prio();
      t_ignored();
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule